// File: doc/BRIEF.md
# Synchronizable Triangle-Count PWM Timebase

This block is a PWM time base that counts a symmetric triangle: it rises from zero to the active period value, then falls back to zero, and repeats. A single compare value splits each triangle into a high and a low phase for output A. Output B is always the inverse of A. The block marks the zero point and the peak of every triangle with single-cycle event flags. It also emits a sync-out strobe of fixed width once per triangle, starting just after the zero point.

A second controller can be locked to the first. The first controller's strobe, or any other pulse, enters the second one on the sync input. That input passes through a two-stage synchronizer and a rising-edge detector. On each detected edge the counter jumps to a programmable phase value and starts counting upward. The phase value offsets the delay that the link between the two controllers adds.

The period and compare inputs are buffered. New values take effect only at the zero point of the count, so a triangle never changes shape part-way through. All pins are plain control or status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `sync_triangle_pwm`

## Requirements
- R1: While reset is asserted the count is zero, the active period and compare values are zero, and the outputs are: zero_evt=1, peak_evt=0, pwm_a=0, pwm_b=1, sync_out=0.
- R2: The count steps by one on each clock. It rises from 0 to the active period P, turns to fall on the cycle after it equals P, and reaches 0 again, so one full triangle lasts 2*P clocks. With P=0 the count stays at 0.
- R3: zero_evt is 1 exactly in the cycles where the count is 0. peak_evt is 1 exactly in the cycles where the count equals a nonzero active period.
- R4: pwm_a is 1 while the count is strictly less than the active compare value. pwm_b is always the inverse of pwm_a.
- R5: period_in and cmp_in are captured into the active registers only at a clock edge where the count is 0. A change at any other time has no effect on the outputs until the next zero point.
- R6: A rising edge on sync_in loads the phase value into the count and sets the direction to up. The loaded count is visible after the third rising clock edge that follows the change on sync_in. A pulse of any width causes exactly one load.
- R7: A phase value larger than the period in force at the load is clamped to that period.
- R8: sync_out goes high one clock after a cycle with count 0 and stays high for exactly SYNC_LEN (default 8) cycles. A zero point that occurs while the pulse is high does not restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_in | input | CNT_W | Period value, buffered until the count reaches zero |
| phase_in | input | CNT_W | Count value loaded on a sync event |
| cmp_in | input | CNT_W | Compare value for output A, buffered until the count reaches zero |
| sync_in | input | 1 | Asynchronous sync request; acts on its rising edge |
| pwm_a | output | 1 | High while count < active compare |
| pwm_b | output | 1 | Inverse of pwm_a |
| zero_evt | output | 1 | Count equals zero |
| peak_evt | output | 1 | Count equals nonzero active period |
| sync_out | output | 1 | Fixed-width strobe after each zero point |

## Verification
pwm_a, pwm_b, zero_evt and peak_evt are decoded from registers, so they follow the count in the same cycle. sync_out lags the zero cycle by one clock. A sync_in edge takes effect after three clock edges. The bench updates its reference model at each rising edge and compares every output at the following falling edge, so each result is read in the cycle it is due. Directed checks sample at these same offsets: three edges after a sync edge, one edge after a mid-cycle compare change, and over whole triangles for period length and strobe width.

// File: rtl/stpwm_pkg.sv
package stpwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;

  function automatic logic [31:0] clamp_to(input logic [31:0] val, input logic [31:0] lim);
    return (val > lim) ? lim : val;
  endfunction
endpackage

// File: rtl/stpwm_sync_detect.sv
module stpwm_sync_detect #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise_pulse
);
  localparam int CHAIN = STAGES + 1;

  logic [CHAIN-1:0] chain_q;

  generate
    for (genvar i = 0; i < CHAIN; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= async_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  // last synchronized stage high, one-cycle-older copy low
  assign rise_pulse = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/stpwm_timebase.sv
module stpwm_timebase
  import stpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             load_phase,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] prd_act,
  output logic [CNT_W-1:0] cmp_act,
  output logic             at_zero
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  cnt_dir_e         dir_q;
  logic [CNT_W-1:0] prd_use;
  logic [CNT_W-1:0] phase_cl;

  assign at_zero  = (cnt == ZERO);
  // the buffered period is adopted at the zero point, so use it there already
  assign prd_use  = at_zero ? period_in : prd_act;
  assign phase_cl = CNT_W'(clamp_to(32'(phase_in), 32'(prd_use)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_act <= ZERO;
      cmp_act <= ZERO;
    end else if (at_zero) begin
      prd_act <= period_in;
      cmp_act <= cmp_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= ZERO;
      dir_q <= DIR_UP;
    end else if (load_phase) begin
      cnt   <= phase_cl;
      dir_q <= DIR_UP;
    end else if (at_zero) begin
      dir_q <= DIR_UP;
      cnt   <= (prd_use == ZERO) ? ZERO : ONE;
    end else if (dir_q == DIR_UP) begin
      if (cnt >= prd_use) begin
        dir_q <= DIR_DOWN;
        cnt   <= cnt - ONE;
      end else begin
        cnt   <= cnt + ONE;
      end
    end else begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/stpwm_compare_out.sv
module stpwm_compare_out #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] prd_act,
  input  logic [CNT_W-1:0] cmp_act,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             zero_evt,
  output logic             peak_evt
);
  always_comb begin
    pwm_a    = (cnt < cmp_act);
    pwm_b    = ~pwm_a;
    zero_evt = (cnt == '0);
    peak_evt = (prd_act != '0) && (cnt == prd_act);
  end
endmodule

// File: rtl/stpwm_sync_stretch.sv
module stpwm_sync_stretch #(
  parameter int SYNC_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic strobe
);
  localparam int LW = $clog2(SYNC_LEN + 1);
  localparam logic [LW-1:0] LEN_V = LW'(SYNC_LEN);

  logic [LW-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                          remain_q <= '0;
    else if (trigger && remain_q == '0)  remain_q <= LEN_V;
    else if (remain_q != '0)             remain_q <= remain_q - LW'(1);
  end

  assign strobe = (remain_q != '0);
endmodule

// File: rtl/sync_triangle_pwm.sv
module sync_triangle_pwm #(
  parameter int CNT_W      = 16,
  parameter int SYNC_LEN   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_in,
  input  logic [CNT_W-1:0] phase_in,
  input  logic [CNT_W-1:0] cmp_in,
  input  logic             sync_in,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             zero_evt,
  output logic             peak_evt,
  output logic             sync_out
);
  logic             sync_pulse;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] prd_act;
  logic [CNT_W-1:0] cmp_act;
  logic             at_zero;

  stpwm_sync_detect #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(sync_in), .rise_pulse(sync_pulse)
  );

  stpwm_timebase #(.CNT_W(CNT_W)) u_tb (
    .clk(clk), .rst_n(rst_n), .period_in(period_in), .phase_in(phase_in),
    .cmp_in(cmp_in), .load_phase(sync_pulse), .cnt(cnt), .prd_act(prd_act),
    .cmp_act(cmp_act), .at_zero(at_zero)
  );

  stpwm_compare_out #(.CNT_W(CNT_W)) u_cmp (
    .cnt(cnt), .prd_act(prd_act), .cmp_act(cmp_act), .pwm_a(pwm_a),
    .pwm_b(pwm_b), .zero_evt(zero_evt), .peak_evt(peak_evt)
  );

  stpwm_sync_stretch #(.SYNC_LEN(SYNC_LEN)) u_sout (
    .clk(clk), .rst_n(rst_n), .trigger(at_zero), .strobe(sync_out)
  );
endmodule

// File: rtl/stpwm_checker.sv
module stpwm_checker #(
  parameter int CNT_W    = 16,
  parameter int SYNC_LEN = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_out,
  input logic             zero_evt,
  input logic             peak_evt,
  input logic             sync_pulse,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] prd_act
);
  logic [31:0] hi_len;

  always_ff @(posedge clk) begin
    if (!rst_n)       hi_len <= 0;
    else if (sync_out) hi_len <= hi_len + 1;
    else              hi_len <= 0;
  end

  assert_events_exclusive_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(zero_evt && peak_evt));

  assert_unit_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> ((cnt - $past(cnt)) == 1 || ($past(cnt) - cnt) == 1 || cnt == $past(cnt)));

  assert_one_load_per_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  assert_load_within_period_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> cnt <= prd_act);

  assert_strobe_after_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_out) |-> $past(zero_evt));

  assert_strobe_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sync_out) |-> hi_len == SYNC_LEN);
endmodule

bind sync_triangle_pwm stpwm_checker #(.CNT_W(CNT_W), .SYNC_LEN(SYNC_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_out(sync_out), .zero_evt(zero_evt),
  .peak_evt(peak_evt), .sync_pulse(sync_pulse), .cnt(cnt), .prd_act(prd_act)
);

// File: tb/sync_triangle_pwm_bench.sv
module sync_triangle_pwm_bench;
  localparam int W = 16;
  localparam int SLEN = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] period_in = '0, phase_in = '0, cmp_in = '0;
  logic sync_in = 1'b0;
  logic pwm_a, pwm_b, zero_evt, peak_evt, sync_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sync_triangle_pwm #(.CNT_W(W), .SYNC_LEN(SLEN)) u_sync_triangle_pwm (
    .clk(clk), .rst_n(rst_n), .period_in(period_in), .phase_in(phase_in),
    .cmp_in(cmp_in), .sync_in(sync_in), .pwm_a(pwm_a), .pwm_b(pwm_b),
    .zero_evt(zero_evt), .peak_evt(peak_evt), .sync_out(sync_out)
  );

  // behavioural reference model
  int m_cnt, m_prd, m_cmp, m_so;
  bit m_up;
  bit sh[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_prd = 0; m_cmp = 0; m_so = 0; m_up = 1;
      sh = '{0, 0, 0};
    end else begin
      int pu;
      bit edge_seen, was_zero;
      edge_seen = sh[1] && !sh[2];
      sh.push_front(sync_in);
      void'(sh.pop_back());
      was_zero = (m_cnt == 0);
      pu = was_zero ? int'(period_in) : m_prd;
      if (m_so == 0 && was_zero) m_so = SLEN;
      else if (m_so > 0) m_so--;
      if (was_zero) begin m_prd = period_in; m_cmp = cmp_in; end
      if (edge_seen) begin
        m_cnt = (int'(phase_in) > pu) ? pu : int'(phase_in);
        m_up = 1;
      end else if (was_zero) begin
        m_up = 1; m_cnt = (pu == 0) ? 0 : 1;
      end else if (m_up) begin
        if (m_cnt >= pu) begin m_up = 0; m_cnt--; end
        else m_cnt++;
      end else m_cnt--;
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // every-cycle comparison at the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ea;
      ea = (m_cnt < m_cmp) ? 1 : 0;
      check("R3", "zero_evt", int'(zero_evt), (m_cnt == 0) ? 1 : 0);
      check("R3", "peak_evt", int'(peak_evt), (m_prd != 0 && m_cnt == m_prd) ? 1 : 0);
      check("R4", "pwm_a", int'(pwm_a), ea);
      check("R4", "pwm_b", int'(pwm_b), 1 - ea);
      check("R8", "sync_out", int'(sync_out), (m_so != 0) ? 1 : 0);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_zero();
    @(negedge clk);
    while (!zero_evt) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not complete actual=hung expected=done");
    finish_run();
  end

  initial begin
    int len;
    step(3);
    // R1 reset state
    check("R1", "zero_evt in reset", int'(zero_evt), 1);
    check("R1", "peak_evt in reset", int'(peak_evt), 0);
    check("R1", "pwm_a in reset", int'(pwm_a), 0);
    check("R1", "pwm_b in reset", int'(pwm_b), 1);
    check("R1", "sync_out in reset", int'(sync_out), 0);

    period_in = 20; cmp_in = 8; phase_in = 0;
    rst_n = 1'b1;
    step(50);
    // R2 triangle length 2*P
    wait_zero(); len = 0;
    do begin @(negedge clk); len++; end while (!zero_evt);
    check("R2", "triangle length P=20", len, 40);
    // R8 strobe width
    wait_zero(); @(negedge clk); len = 0;
    while (sync_out) begin len++; @(negedge clk); end
    check("R8", "sync_out width", len, SLEN);

    // R5 compare change mid-rise is held until zero
    wait_zero(); step(12);
    cmp_in = 30;
    step(1);
    check("R5", "pwm_a keeps old compare", int'(pwm_a), 0);
    wait_zero();
    check("R5", "pwm_a after zero uses new compare", int'(pwm_a), 1);
    cmp_in = 8;

    // R5 period change takes effect at next zero
    step(5); period_in = 12;
    wait_zero(); len = 0;
    do begin @(negedge clk); len++; end while (!zero_evt);
    check("R5", "triangle length after new period", len, 24);

    // R6 load on rising edge, visible after three clock edges
    step(3);
    phase_in = 12; sync_in = 1'b1;
    step(2);
    step(1);
    check("R6", "peak after phase load", int'(peak_evt), 1);
    step(20);
    sync_in = 1'b0;
    check("R6", "long pulse loads once (falling away from peak)", int'(peak_evt), 0);
    step(10);

    // R7 clamp of oversized phase
    phase_in = 200; sync_in = 1'b1;
    step(3);
    check("R7", "clamped phase hits peak", int'(peak_evt), 1);
    sync_in = 1'b0;
    step(4);
    // phase zero load
    phase_in = 0; sync_in = 1'b1;
    step(3);
    check("R6", "phase zero load gives zero", int'(zero_evt), 1);
    sync_in = 1'b0;
    step(30);

    // R2 full scale: P=5000
    period_in = 5000; cmp_in = 2500;
    wait_zero(); wait_zero(); len = 0;
    do begin @(negedge clk); len++; end while (!zero_evt);
    check("R2", "triangle length P=5000", len, 10000);

    // R2 period zero holds count at zero
    period_in = 0;
    wait_zero(); step(3);
    check("R2", "period zero holds zero", int'(zero_evt), 1);
    step(20);
    finish_run();
  end
endmodule